// File: doc/BRIEF.md
# SIMD Halving and Saturating Lane ALU

This unit applies one arithmetic operation to every lane of two packed operand vectors at once. A lane can be 8, 16 or 32 bits wide, and the width is chosen on each transfer. The operations are saturating add and subtract, the halving sum (average), the halving difference (negative average), rounded forms of both, and clamped forms of the rounded halving difference. Each operation has an unsigned form and a signed form. A rounding-offset helper is also included. Alongside the lane result, the unit reports the carry out of a 32-bit add for every 32-bit word of the operands.

All lane arithmetic is exact. Operands are widened before any add or subtract, so a halving or clamping step never sees a wrapped intermediate. The result is captured in a register and appears one clock after the input is presented.

Top module: `simd_avg_alu`

## Requirements
- R1: While reset is high and on the first clock after it, `out_valid` is 0, `result_o` is all zeros and `carry_o` is all zeros.
- R2: A transfer presented with `in_valid`=1 at a rising edge appears on `result_o` and `carry_o` after that edge, with `out_valid`=1. `out_valid` is `in_valid` delayed by one clock.
- R3: At an edge where `in_valid`=0, `result_o` and `carry_o` keep their values whatever the other inputs are.
- R4: For op codes 0 to 13, an odd op code makes the operands signed and they are sign-extended. An even op code makes them unsigned and they are zero-extended. Both operands are widened beyond twice the lane width before they are added or subtracted.
- R5: Op codes 0/1 give the saturating sum and 2/3 give the saturating difference (U-V). The exact result is clamped to [0, 2^W-1] when unsigned and to [-2^(W-1), 2^(W-1)-1] when signed.
- R6: Op codes 4/5 give floor((U+V)/2). Op codes 6/7 give floor((U+V+1)/2).
- R7: Op codes 8/9 give floor((U-V)/2). Op codes 10/11 give floor((U-V+1)/2). For R6 and R7 the lane keeps the low W bits of the result.
- R8: Op codes 12/13 give floor((U-V+1)/2), clamped to the unsigned or signed lane range.
- R9: Op code 14 is the rounding helper. With s equal to the low log2(W) bits of V, the lane result is U + 2^(s-1) modulo 2^W when s>0, and U when s=0.
- R10: Op code 15 gives all zeros in every lane.
- R11: `width_i` 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes. Lanes never interact.
- R12: `carry_o[k]` is bit 32 of A[32k+31:32k] + B[32k+31:32k] + `carry_in_i`. All three terms are zero-extended. This holds for every op code and lane width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_i | input | 4 | Operation code (see R5 to R10) |
| width_i | input | 2 | Lane width select |
| a_i | input | VEC_BITS | Operand vector U |
| b_i | input | VEC_BITS | Operand vector V |
| carry_in_i | input | 1 | Carry input for the 32-bit word adds |
| out_valid | output | 1 | Registered result is new |
| result_o | output | VEC_BITS | Registered lane results |
| carry_o | output | VEC_BITS/32 | Registered per-word carry outputs |

## Verification
The hardest cases to reach are the lanes where a halving difference is negative and then clamped. An unsigned operand pair with U < V has to produce 0 rather than a huge logical-shift value. A signed difference has to exceed the lane range only after halving with rounding. Uniform random operands seldom hit the exact edges, so the bench adds directed vectors that fill every lane with extreme values such as 0x00, 0x7F, 0x80 and 0xFF, and checks them in every width. The random stream then covers all op codes and widths, including the reserved width code and op code 15.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

    typedef enum logic [3:0] {
        OP_ADDS_U  = 4'd0,
        OP_ADDS_S  = 4'd1,
        OP_SUBS_U  = 4'd2,
        OP_SUBS_S  = 4'd3,
        OP_AVG_U   = 4'd4,
        OP_AVG_S   = 4'd5,
        OP_AVGR_U  = 4'd6,
        OP_AVGR_S  = 4'd7,
        OP_NAVG_U  = 4'd8,
        OP_NAVG_S  = 4'd9,
        OP_NAVGR_U = 4'd10,
        OP_NAVGR_S = 4'd11,
        OP_NAVGC_U = 4'd12,
        OP_NAVGC_S = 4'd13,
        OP_RNDOFS  = 4'd14,
        OP_ZERO    = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        LW_8   = 2'd0,
        LW_16  = 2'd1,
        LW_32  = 2'd2,
        LW_32B = 2'd3
    } lane_w_e;

    typedef struct packed {
        logic    valid;
        alu_op_e op;
        lane_w_e width;
        logic    cin;
    } ctl_t;

    function automatic logic op_is_signed(input alu_op_e op);
        return op[0] && (op != OP_ZERO);
    endfunction

endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_avg_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   u,
    input  logic [W-1:0]   v,
    output logic [W-1:0]   res
);
    localparam int E  = 2 * W + 2;
    localparam int LW = $clog2(W);
    localparam logic signed [E-1:0] ONE  = E'(1);
    localparam logic signed [E-1:0] SMAX = E'((64'd1 << (W - 1)) - 64'd1);
    localparam logic signed [E-1:0] SMIN = -SMAX - ONE;
    localparam logic signed [E-1:0] UMAX = E'((64'd1 << W) - 64'd1);

    logic                  sgn;
    logic signed [E-1:0]   ue, ve, sum, dif, difr;
    logic [LW-1:0]         shamt;
    logic [W-1:0]          rnd_add;

    function automatic logic [W-1:0] clampw(input logic signed [E-1:0] x, input logic s);
        if (s) begin
            if (x > SMAX) return SMAX[W-1:0];
            if (x < SMIN) return SMIN[W-1:0];
        end else begin
            if (x > UMAX) return UMAX[W-1:0];
            if (x < 0)    return '0;
        end
        return x[W-1:0];
    endfunction

    always_comb begin
        sgn  = op_is_signed(op);
        ue   = sgn ? {{(E-W){u[W-1]}}, u} : {{(E-W){1'b0}}, u};
        ve   = sgn ? {{(E-W){v[W-1]}}, v} : {{(E-W){1'b0}}, v};
        sum  = ue + ve;
        dif  = ue - ve;
        difr = (dif + ONE) >>> 1;
        shamt   = v[LW-1:0];
        rnd_add = (shamt == '0) ? '0 : (W'(1) << (shamt - LW'(1)));
        unique case (op)
            OP_ADDS_U, OP_ADDS_S:   res = clampw(sum, sgn);
            OP_SUBS_U, OP_SUBS_S:   res = clampw(dif, sgn);
            OP_AVG_U,  OP_AVG_S:    res = W'(sum >>> 1);
            OP_AVGR_U, OP_AVGR_S:   res = W'((sum + ONE) >>> 1);
            OP_NAVG_U, OP_NAVG_S:   res = W'(dif >>> 1);
            OP_NAVGR_U, OP_NAVGR_S: res = W'(difr);
            OP_NAVGC_U, OP_NAVGC_S: res = clampw(difr, sgn);
            OP_RNDOFS:              res = u + rnd_add;
            default:                res = '0;
        endcase
    end
endmodule

// File: rtl/simd_carry.sv
module simd_carry #(
    parameter int NW = 2
) (
    input  logic [NW*32-1:0] a,
    input  logic [NW*32-1:0] b,
    input  logic             cin,
    output logic [NW-1:0]    cout
);
    for (genvar k = 0; k < NW; k++) begin : g_word
        logic [32:0] s;
        assign s       = {1'b0, a[k*32 +: 32]} + {1'b0, b[k*32 +: 32]} + {32'd0, cin};
        assign cout[k] = s[32];
    end
endmodule

// File: rtl/simd_avg_alu.sv
module simd_avg_alu
    import simd_avg_pkg::*;
#(
    parameter int VEC_BITS = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [3:0]            op_i,
    input  logic [1:0]            width_i,
    input  logic [VEC_BITS-1:0]   a_i,
    input  logic [VEC_BITS-1:0]   b_i,
    input  logic                  carry_in_i,
    output logic                  out_valid,
    output logic [VEC_BITS-1:0]   result_o,
    output logic [VEC_BITS/32-1:0] carry_o
);
    localparam int N8  = VEC_BITS / 8;
    localparam int N16 = VEC_BITS / 16;
    localparam int N32 = VEC_BITS / 32;

    ctl_t                  ctl;
    logic [VEC_BITS-1:0]   r8, r16, r32, nxt;
    logic [N32-1:0]        cnxt;

    assign ctl = '{valid: in_valid, op: alu_op_e'(op_i),
                   width: lane_w_e'(width_i), cin: carry_in_i};

    for (genvar i = 0; i < N8; i++) begin : g_l8
        simd_lane #(.W(8)) u_lane (.op(ctl.op), .u(a_i[i*8 +: 8]),
                                   .v(b_i[i*8 +: 8]), .res(r8[i*8 +: 8]));
    end
    for (genvar i = 0; i < N16; i++) begin : g_l16
        simd_lane #(.W(16)) u_lane (.op(ctl.op), .u(a_i[i*16 +: 16]),
                                    .v(b_i[i*16 +: 16]), .res(r16[i*16 +: 16]));
    end
    for (genvar i = 0; i < N32; i++) begin : g_l32
        simd_lane #(.W(32)) u_lane (.op(ctl.op), .u(a_i[i*32 +: 32]),
                                    .v(b_i[i*32 +: 32]), .res(r32[i*32 +: 32]));
    end

    simd_carry #(.NW(N32)) u_carry (.a(a_i), .b(b_i), .cin(ctl.cin), .cout(cnxt));

    always_comb begin
        unique case (ctl.width)
            LW_8:    nxt = r8;
            LW_16:   nxt = r16;
            default: nxt = r32;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result_o  <= '0;
            carry_o   <= '0;
        end else begin
            out_valid <= ctl.valid;
            if (ctl.valid) begin
                result_o <= nxt;
                carry_o  <= cnxt;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R3
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(result_o) && $stable(carry_o)));
    // R5
    usat_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd0 && width_i == 2'd2)
        |=> result_o[31:0] >= $past(a_i[31:0]));
    // R6
    avg_between_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd4 && width_i == 2'd0 && a_i[7:0] <= b_i[7:0])
        |=> (result_o[7:0] >= $past(a_i[7:0]) && result_o[7:0] <= $past(b_i[7:0])));
    // R10
    zero_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_i == 4'd15) |=> result_o == '0);
    // R12
    carry_none_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b_i[31:0] == 32'd0 && !carry_in_i) |=> !carry_o[0]);
endmodule

// File: tb/simd_avg_alu_test.sv
module simd_avg_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam int VB = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [3:0]    op_i;
    logic [1:0]    width_i;
    logic [VB-1:0] a_i, b_i;
    logic          carry_in_i;
    logic          out_valid;
    logic [VB-1:0] result_o;
    logic [1:0]    carry_o;

    int checks = 0;
    int errors = 0;

    simd_avg_alu #(.VEC_BITS(VB)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i), .width_i(width_i),
        .a_i(a_i), .b_i(b_i), .carry_in_i(carry_in_i),
        .out_valid(out_valid), .result_o(result_o), .carry_o(carry_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic longint clampv(longint x, longint lo, longint hi);
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction

    function automatic logic [VB-1:0] ref_vec(logic [3:0] op, logic [1:0] ws,
                                              logic [VB-1:0] a, logic [VB-1:0] b);
        int w;
        logic [VB-1:0] out;
        w = (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
        out = '0;
        for (int i = 0; i < VB / w; i++) begin
            longint mask, u, v, r, lo, hi, s;
            bit sg;
            mask = (longint'(1) << w) - 1;
            u = longint'((a >> (i*w))) & mask;
            v = longint'((b >> (i*w))) & mask;
            s = v & (w - 1);
            sg = op[0] && op != 4'd15;
            if (sg) begin
                if (u >= (longint'(1) << (w-1))) u = u - (longint'(1) << w);
                if (v >= (longint'(1) << (w-1))) v = v - (longint'(1) << w);
                lo = -(longint'(1) << (w-1)); hi = (longint'(1) << (w-1)) - 1;
            end else begin
                lo = 0; hi = mask;
            end
            case (op)
                4'd0, 4'd1:   r = clampv(u + v, lo, hi);
                4'd2, 4'd3:   r = clampv(u - v, lo, hi);
                4'd4, 4'd5:   r = (u + v) >>> 1;
                4'd6, 4'd7:   r = (u + v + 1) >>> 1;
                4'd8, 4'd9:   r = (u - v) >>> 1;
                4'd10, 4'd11: r = (u - v + 1) >>> 1;
                4'd12, 4'd13: r = clampv((u - v + 1) >>> 1, lo, hi);
                4'd14:        r = (u & mask) + ((s > 0) ? (longint'(1) << (s-1)) : 0);
                default:      r = 0;
            endcase
            out = out | (VB'(r & mask) << (i*w));
        end
        return out;
    endfunction

    function automatic logic [1:0] ref_carry(logic [VB-1:0] a, logic [VB-1:0] b, logic c);
        logic [1:0] o;
        for (int k = 0; k < 2; k++) begin
            logic [32:0] s;
            s = {1'b0, a[k*32 +: 32]} + {1'b0, b[k*32 +: 32]} + {32'd0, c};
            o[k] = s[32];
        end
        return o;
    endfunction

    task automatic chk(string tag, logic [VB-1:0] act, logic [VB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(string tag, logic [3:0] op, logic [1:0] ws,
                         logic [VB-1:0] a, logic [VB-1:0] b, logic c);
        @(negedge clk);
        in_valid = 1'b1; op_i = op; width_i = ws; a_i = a; b_i = b; carry_in_i = c;
        @(posedge clk); #1;
        chk({tag, " R2 valid"}, VB'(out_valid), VB'(1));
        chk(tag, result_o, ref_vec(op, ws, a, b));
        chk({tag, " R12 carry"}, VB'(carry_o), VB'(ref_carry(a, b, c)));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL R2 watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VB-1:0] held;
        logic [1:0]    heldc;
        rst = 1'b1; in_valid = 1'b0; op_i = '0; width_i = '0;
        a_i = '1; b_i = '1; carry_in_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid", VB'(out_valid), '0);
        chk("R1 result", result_o, '0);
        chk("R1 carry", VB'(carry_o), '0);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 first cycle", result_o, '0);

        // directed corners in every width
        for (int ws = 0; ws < 4; ws++) begin
            apply("R5 uadd sat", 4'd0, 2'(ws), '1, {VB/8{8'h01}}, 1'b0);
            apply("R5 sadd sat", 4'd1, 2'(ws), {VB/8{8'h7F}}, {VB/8{8'h7F}}, 1'b0);
            apply("R5 ssub sat", 4'd3, 2'(ws), {VB/8{8'h80}}, {VB/8{8'h01}}, 1'b0);
            apply("R5 usub sat", 4'd2, 2'(ws), '0, {VB/8{8'h01}}, 1'b0);
            apply("R6 avg rnd", 4'd6, 2'(ws), '1, {VB/8{8'h00}}, 1'b0);
            apply("R6 savg", 4'd5, 2'(ws), {VB/8{8'h80}}, {VB/8{8'hFF}}, 1'b0);
            apply("R7 unavg neg", 4'd8, 2'(ws), '0, '1, 1'b0);
            apply("R7 snavg rnd", 4'd11, 2'(ws), {VB/8{8'h80}}, {VB/8{8'h01}}, 1'b0);
            apply("R8 unavg clamp", 4'd12, 2'(ws), '0, '1, 1'b0);
            apply("R8 snavg clamp hi", 4'd13, 2'(ws), {VB/8{8'h7F}}, {VB/8{8'h80}}, 1'b0);
            apply("R8 snavg clamp lo", 4'd13, 2'(ws), {VB/8{8'h80}}, {VB/8{8'h7F}}, 1'b0);
            apply("R9 round zero shift", 4'd14, 2'(ws), {VB/8{8'h5A}}, '0, 1'b0);
            apply("R9 round max shift", 4'd14, 2'(ws), {VB/8{8'hF0}}, '1, 1'b0);
            apply("R10 zero op", 4'd15, 2'(ws), '1, '1, 1'b1);
            apply("R4 sign vs zero ext", 4'd4, 2'(ws), {VB/8{8'hFE}}, {VB/8{8'h02}}, 1'b0);
            apply("R4 signed ext", 4'd5, 2'(ws), {VB/8{8'hFE}}, {VB/8{8'h02}}, 1'b0);
        end
        apply("R12 carry from cin", 4'd0, 2'd2, 64'h0000_0000_FFFF_FFFF, '0, 1'b1);
        apply("R11 lane isolation", 4'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0);
        apply("R11 16-bit lanes", 4'd0, 2'd1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 1'b0);

        // R3: hold when in_valid low
        held = result_o; heldc = carry_o;
        @(negedge clk);
        in_valid = 1'b0; op_i = 4'd0; a_i = 64'h1234_5678_9ABC_DEF0; b_i = '1; carry_in_i = 1'b1;
        @(posedge clk); #1;
        chk("R2 valid drops", VB'(out_valid), '0);
        chk("R3 result held", result_o, held);
        chk("R3 carry held", VB'(carry_o), VB'(heldc));

        void'($urandom(32'd4242));
        for (int n = 0; n < 400; n++) begin
            logic [VB-1:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            apply("R4 R11 random", 4'($urandom % 16), 2'($urandom % 4), ra, rb, 1'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule